// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block steps a small processor subsystem between its full-power run state and four progressively deeper low-power states: a light sleep, a deep sleep, a power-down and a deep power-down. A one-cycle sleep request, standing in for a wait-for-interrupt or wait-for-event, starts the entry. A deep-sleep flag sampled with the request picks between the light sleep and whichever deep state a small configuration register holds. Hardware wake events bring the subsystem back. Every return goes to the run state, and the controller never moves directly from one low-power state to another.

The controller owns the CPU clock enable and one clock enable per peripheral. It also drives a per-peripheral power mask, a flag that tells the supply logic the run sub-mode is the slow, reduced-voltage one, a 3-bit code for the current mode, and a one-cycle pulse when a wake-up completes. Light sleep gates only the CPU clock. The deep states also gate every peripheral clock. The order is fixed: on entry the CPU clock stops one cycle before the peripheral clocks, and on wake the peripheral clocks return one cycle before the CPU clock. Three configuration values are loaded through a simple write port: the deep target, the power mask and the run sub-mode.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the mode code is 0 (Active) and the CPU clock is enabled. The power mask is all ones, so every peripheral clock is on. The deep target is 00, the sub-mode is 0 and the low-power flag reads 0.
- R2: In Active, a sleep request with the deep-sleep flag at 0 moves the controller to Sleep (code 1) at the next edge. The CPU clock is then off, and each peripheral clock keeps following its power mask bit.
- R3: In Active, a sleep request with the deep-sleep flag at 1 selects the deep state from the target register. Target 00 gives code 2 (Deep-sleep), 01 gives code 3 (Power-down), 10 gives code 4 (Deep power-down), and 11 also gives code 2.
- R4: While the code is non-zero, a sleep request is ignored whatever the deep-sleep flag holds, and so is a write to the target register. The code changes only by returning to 0, never to another non-zero value.
- R5: A deep entry takes two cycles. In the first cycle after the request, the CPU clock is off, the peripheral clocks still follow the mask, and the code already shows the deep state. From the cycle after that, all peripheral clocks are off.
- R6: Any wake event bit at 1, sampled in Sleep or in a settled deep state, starts the wake. Sleep returns to Active (CPU clock on) at the next edge. A deep state first restores the peripheral clocks for one cycle, with the CPU clock still off, and then returns to Active. Wake events seen in Active have no effect.
- R7: The wake-done output is high for exactly the first Active cycle after any low-power state, and at no other time.
- R8: A peripheral clock enable is never high while its power mask bit is 0. The power mask output always equals the mask register.
- R9: The low-power flag equals the sub-mode bit in Active and in Sleep, and is 0 in every deep state.
- R10: A write with select 0 loads the target from data bits [1:0]. Select 1 loads the mask from the whole data word. Select 2 loads the sub-mode from data bit 0. Select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep request strobe |
| deep_flag | input | 1 | 1 selects a deep state for the request |
| wake_evt | input | NUM_WAKE | Hardware wake events, any bit wakes |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | 0 target, 1 mask, 2 sub-mode, 3 none |
| cfg_wr_data | input | NUM_PERIPH | Configuration write data |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| periph_pwr | output | NUM_PERIPH | Per-peripheral power mask |
| lowpwr_flag | output | 1 | Slow-clock, reduced-voltage sub-mode active |
| mode_code | output | 3 | Current mode, 0 Active to 4 Deep power-down |
| wake_done | output | 1 | One-cycle pulse on return to Active |

## Verification
The hardest situation to reach from the ports is the middle of a deep entry or a deep wake. During the one gating cycle, and the one peripheral-restore cycle, the CPU clock and the peripheral clocks disagree. The bench samples right after each edge of a full entry-and-wake sequence, so it sees both single-cycle windows. It runs that sequence for every combination of target value, deep-sleep flag, sub-mode and 4-bit mask pattern. Inside each low-power stay it also fires a sleep request with the opposite flag and writes a different target, to show that neither moves the mode.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_GATE   = 3'd2,
    ST_DEEP   = 3'd3,
    ST_UNGATE = 3'd4
  } seq_state_t;

  localparam logic [2:0] MODE_ACTIVE = 3'd0;
  localparam logic [2:0] MODE_SLEEP  = 3'd1;
  localparam logic [2:0] MODE_DSLEEP = 3'd2;
  localparam logic [2:0] MODE_PDOWN  = 3'd3;
  localparam logic [2:0] MODE_DPDOWN = 3'd4;

  localparam logic [1:0] SEL_TARGET  = 2'd0;
  localparam logic [1:0] SEL_MASK    = 2'd1;
  localparam logic [1:0] SEL_SUBMODE = 2'd2;

  // Map the 2-bit deep target to a mode code; the spare value falls back to deep sleep.
  function automatic logic [2:0] deep_code(input logic [1:0] tgt);
    logic [2:0] code;
    case (tgt)
      2'b01:   code = MODE_PDOWN;
      2'b10:   code = MODE_DPDOWN;
      default: code = MODE_DSLEEP;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs #(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [NUM_PERIPH-1:0] wr_data,
  output logic [1:0]            tgt,
  output logic [NUM_PERIPH-1:0] pwr_mask,
  output logic                  submode
);
  import pwr_seq_pkg::*;

  logic                  tgt_we, mask_we, sub_we;
  logic [1:0]            tgt_n;
  logic [NUM_PERIPH-1:0] mask_n;
  logic                  sub_n;

  always_comb begin
    tgt_we  = wr_en && (wr_sel == SEL_TARGET);
    mask_we = wr_en && (wr_sel == SEL_MASK);
    sub_we  = wr_en && (wr_sel == SEL_SUBMODE);
    tgt_n   = tgt_we  ? wr_data[1:0] : tgt;
    mask_n  = mask_we ? wr_data      : pwr_mask;
    sub_n   = sub_we  ? wr_data[0]   : submode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt      <= 2'b00;
      pwr_mask <= '1;
      submode  <= 1'b0;
    end else begin
      tgt      <= tgt_n;
      pwr_mask <= mask_n;
      submode  <= sub_n;
    end
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm #(
  parameter int NUM_WAKE = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sleep_req,
  input  logic                          deep_flag,
  input  logic [1:0]                    tgt,
  input  logic [NUM_WAKE-1:0]           wake_evt,
  output pwr_seq_pkg::seq_state_t       state,
  output logic [2:0]                    mode_code,
  output logic                          wake_done
);
  import pwr_seq_pkg::*;

  seq_state_t state_n;
  logic [2:0] mode_n;
  logic       done_n;
  logic       wake_any;

  assign wake_any = |wake_evt;

  always_comb begin
    state_n = state;
    mode_n  = mode_code;
    done_n  = 1'b0;
    case (state)
      ST_RUN: begin
        if (sleep_req) begin
          if (deep_flag) begin
            state_n = ST_GATE;
            mode_n  = deep_code(tgt);
          end else begin
            state_n = ST_SLEEP;
            mode_n  = MODE_SLEEP;
          end
        end
      end
      ST_SLEEP: begin
        if (wake_any) begin
          state_n = ST_RUN;
          mode_n  = MODE_ACTIVE;
          done_n  = 1'b1;
        end
      end
      ST_GATE: begin
        state_n = ST_DEEP;
      end
      ST_DEEP: begin
        if (wake_any) begin
          state_n = ST_UNGATE;
        end
      end
      ST_UNGATE: begin
        state_n = ST_RUN;
        mode_n  = MODE_ACTIVE;
        done_n  = 1'b1;
      end
      default: begin
        state_n = ST_RUN;
        mode_n  = MODE_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      mode_code <= MODE_ACTIVE;
      wake_done <= 1'b0;
    end else begin
      state     <= state_n;
      mode_code <= mode_n;
      wake_done <= done_n;
    end
  end

endmodule

// File: rtl/pwr_clk_gate_ctrl.sv
module pwr_clk_gate_ctrl #(
  parameter int NUM_PERIPH = 4
) (
  input  pwr_seq_pkg::seq_state_t state,
  input  logic [NUM_PERIPH-1:0]   pwr_mask,
  input  logic                    submode,
  output logic                    cpu_clk_en,
  output logic [NUM_PERIPH-1:0]   periph_clk_en,
  output logic                    lowpwr_flag
);
  import pwr_seq_pkg::*;

  logic periph_on;
  logic run_or_sleep;

  always_comb begin
    cpu_clk_en   = (state == ST_RUN);
    periph_on    = (state != ST_DEEP);
    run_or_sleep = (state == ST_RUN) || (state == ST_SLEEP);
    lowpwr_flag  = submode && run_or_sleep;
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_pclk
    assign periph_clk_en[i] = pwr_mask[i] & periph_on;
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NUM_PERIPH = 4,
  parameter int NUM_WAKE   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sleep_req,
  input  logic                  deep_flag,
  input  logic [NUM_WAKE-1:0]   wake_evt,
  input  logic                  cfg_wr_en,
  input  logic [1:0]            cfg_wr_sel,
  input  logic [NUM_PERIPH-1:0] cfg_wr_data,
  output logic                  cpu_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic [NUM_PERIPH-1:0] periph_pwr,
  output logic                  lowpwr_flag,
  output logic [2:0]            mode_code,
  output logic                  wake_done
);
  import pwr_seq_pkg::*;

  logic [1:0]            tgt;
  logic [NUM_PERIPH-1:0] pwr_mask;
  logic                  submode;
  seq_state_t            state;

  pwr_cfg_regs #(.NUM_PERIPH(NUM_PERIPH)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_sel   (cfg_wr_sel),
    .wr_data  (cfg_wr_data),
    .tgt      (tgt),
    .pwr_mask (pwr_mask),
    .submode  (submode)
  );

  pwr_mode_fsm #(.NUM_WAKE(NUM_WAKE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .deep_flag (deep_flag),
    .tgt       (tgt),
    .wake_evt  (wake_evt),
    .state     (state),
    .mode_code (mode_code),
    .wake_done (wake_done)
  );

  pwr_clk_gate_ctrl #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
    .state         (state),
    .pwr_mask      (pwr_mask),
    .submode       (submode),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .lowpwr_flag   (lowpwr_flag)
  );

  assign periph_pwr = pwr_mask;

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int NUM_PERIPH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_clk_en,
  input logic [NUM_PERIPH-1:0] periph_clk_en,
  input logic [NUM_PERIPH-1:0] periph_pwr,
  input logic                  lowpwr_flag,
  input logic [2:0]            mode_code,
  input logic                  wake_done
);

  // R4
  no_lateral_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != 3'd0) |=> (mode_code == 3'd0 || mode_code == $past(mode_code)));

  // R3
  mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code <= 3'd4);

  // R2
  sleep_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd1) |-> (!cpu_clk_en && periph_clk_en == periph_pwr));

  // R5
  cpu_off_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> (periph_clk_en == periph_pwr));

  // R6
  periph_on_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> ($past(periph_clk_en) == $past(periph_pwr)));

  // R7
  wake_done_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (mode_code == 3'd0 && cpu_clk_en));

  // R7
  wake_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);

  // R8
  clk_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_clk_en & ~periph_pwr) == '0);

  // R9
  lowpwr_shallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowpwr_flag |-> (mode_code <= 3'd1));

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .periph_pwr    (periph_pwr),
  .lowpwr_flag   (lowpwr_flag),
  .mode_code     (mode_code),
  .wake_done     (wake_done)
);

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;
  localparam int NP = 4;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_req, deep_flag;
  logic [NW-1:0] wake_evt;
  logic          cfg_wr_en;
  logic [1:0]    cfg_wr_sel;
  logic [NP-1:0] cfg_wr_data;
  logic          cpu_clk_en;
  logic [NP-1:0] periph_clk_en, periph_pwr;
  logic          lowpwr_flag;
  logic [2:0]    mode_code;
  logic          wake_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.NUM_PERIPH(NP), .NUM_WAKE(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .deep_flag(deep_flag),
    .wake_evt(wake_evt), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .periph_pwr(periph_pwr),
    .lowpwr_flag(lowpwr_flag), .mode_code(mode_code), .wake_done(wake_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    cfg_wr_en   = 1'b1;
    cfg_wr_sel  = sel;
    cfg_wr_data = NP'(data);
    tick();
    cfg_wr_en   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; deep_flag = 1'b0; wake_evt = '0;
    cfg_wr_en = 1'b0; cfg_wr_sel = '0; cfg_wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1", "mode", int'(mode_code), 0);
    chk("R1", "cpu_clk_en", int'(cpu_clk_en), 1);
    chk("R1", "periph_pwr", int'(periph_pwr), (1 << NP) - 1);
    chk("R1", "periph_clk_en", int'(periph_clk_en), (1 << NP) - 1);
    chk("R1", "lowpwr_flag", int'(lowpwr_flag), 0);
    chk("R1", "wake_done", int'(wake_done), 0);

    // R6: wake in Active ignored
    wake_evt = '1;
    tick();
    wake_evt = '0;
    chk("R6", "wake in active mode", int'(mode_code), 0);
    chk("R6", "wake in active done", int'(wake_done), 0);

    // R10: select 3 writes nothing
    wr(2'd3, 5);
    chk("R10", "sel3 mask", int'(periph_pwr), (1 << NP) - 1);
    chk("R10", "sel3 lowpwr", int'(lowpwr_flag), 0);

    for (int t = 0; t < 4; t++) begin
      for (int df = 0; df < 2; df++) begin
        for (int s = 0; s < 2; s++) begin
          for (int m = 0; m < (1 << NP); m++) begin
            int code;
            int wbit;
            code = (df == 0) ? 1 : ((t == 3) ? 2 : t + 2);
            wbit = (m + t) % NW;
            wr(2'd1, m);
            wr(2'd2, s);
            wr(2'd0, t);
            chk("R10", "mask write", int'(periph_pwr), m);
            chk("R9", "lowpwr in active", int'(lowpwr_flag), s);
            chk("R8", "clocks follow mask", int'(periph_clk_en), m);
            deep_flag = df[0];
            sleep_req = 1'b1;
            tick();
            sleep_req = 1'b0;
            if (df == 0) begin
              chk("R2", "sleep mode code", int'(mode_code), 1);
              chk("R2", "sleep cpu clk", int'(cpu_clk_en), 0);
              chk("R2", "sleep periph clk", int'(periph_clk_en), m);
              chk("R9", "lowpwr in sleep", int'(lowpwr_flag), s);
            end else begin
              chk("R3", "deep mode code", int'(mode_code), code);
              chk("R5", "gate cycle cpu", int'(cpu_clk_en), 0);
              chk("R5", "gate cycle periph", int'(periph_clk_en), m);
              tick();
              chk("R5", "deep periph off", int'(periph_clk_en), 0);
              chk("R9", "lowpwr in deep", int'(lowpwr_flag), 0);
            end
            // R4: requests and target writes ignored while low-power
            deep_flag = ~df[0];
            sleep_req = 1'b1;
            tick();
            sleep_req = 1'b0;
            chk("R4", "request ignored", int'(mode_code), code);
            wr(2'd0, t ^ 1);
            chk("R4", "target write ignored", int'(mode_code), code);
            chk("R4", "cpu still off", int'(cpu_clk_en), 0);
            wake_evt = NW'(1 << wbit);
            tick();
            wake_evt = '0;
            if (df == 1) begin
              chk("R6", "ungate periph on", int'(periph_clk_en), m);
              chk("R6", "ungate cpu off", int'(cpu_clk_en), 0);
              chk("R7", "no done during ungate", int'(wake_done), 0);
              tick();
            end
            chk("R6", "back to active", int'(mode_code), 0);
            chk("R6", "cpu back on", int'(cpu_clk_en), 1);
            chk("R7", "wake done pulse", int'(wake_done), 1);
            chk("R9", "lowpwr after wake", int'(lowpwr_flag), s);
            tick();
            chk("R7", "wake done one cycle", int'(wake_done), 0);
          end
        end
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule